// File: doc/BRIEF.md
# Shift-Chain Upset Test Controller

This block drives a set of equal-length flip-flop shift chains that serve as targets in a storage-element upset experiment, and reads them back. In static mode it loads every chain with a selectable test pattern and then stops shifting, so the chains sit unclocked while they are exposed. A pause request ends the exposure. The controller then shifts the chains out and compares every bit against the pattern. During that flush it shifts the pattern back in, so the next exposure can begin at once. Each flush sorts its mismatches into two kinds. Scattered single-bit upsets add to one counter. A chain in which a large group of bits has been forced the same way counts as one set/reset event in a separate counter. The exposure cycle repeats until the two counters together reach a target, and the controller then reports done.

In dynamic mode the pattern circulates through the chains without stopping and is compared at the chain outputs. A bit position that is wrong on two consecutive trips through the chain is reported as a stuck element. The chains, the fault sources and the exposure equipment sit outside the block.

Top module: `shift_chain_tester`

## Requirements
- R1: Pattern select is captured on an accepted start. The bit shifted in at index i of a pass (i = 0 .. CHAIN_LEN-1) is 0 for select 00 and 1 for select 01. For select 10 it is i[0], an alternating pattern that starts with 0. For select 11 it is the inverse of i[0]. All chains receive the same bit.
- R2: A static run begins with exactly CHAIN_LEN shift cycles. Then shifting stops and `exposing` is high until a pause is seen. After a pause the controller performs exactly CHAIN_LEN shift cycles, spends one cycle on classification, and returns to exposing.
- R3: During a flush, the chain output at shift j is compared with pattern bit j. That is the bit shifted in CHAIN_LEN cycles earlier. The flush shifts the pattern back in, so the chains are refilled for the next exposure.
- R4: In a chain that is not classified as a set/reset event, each flushed mismatch adds one to `upset_count`. A flush with no mismatches leaves both counters unchanged.
- R5: A chain whose flush shows at least CHAIN_LEN/4 mismatches, all in the same direction, adds exactly one to `mass_count` and nothing to `upset_count`. Mismatches in both directions are counted as separate upsets, whatever their number.
- R6: After a classification that brings `upset_count + mass_count` to at least TARGET_EVENTS (100 by default), `done` goes high and stays high and shifting stops. Only a new start leaves this state. Pause has no effect while done.
- R7: In dynamic mode the chains shift on every cycle. The first CHAIN_LEN cycles only prime the chains. From then on, every output bit is compared with the pattern bit at the same index. A pause returns the block to idle.
- R8: In dynamic mode, a chain and index pair that mismatches on two consecutive passes adds one to `stuck_count`, only once per pair per run, and sets `stuck_seen`. A mismatch that does not repeat on the next pass adds nothing.
- R9: The three counters are CNT_W bits wide (16 by default). They saturate at their maximum instead of wrapping, and an accepted start clears them.
- R10: Start is accepted only while idle or done. Pause acts only while exposing or in dynamic mode. Anywhere else both are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (one-cycle pulse) |
| pause | input | 1 | End the exposure or stop dynamic mode (one-cycle pulse) |
| dyn_mode | input | 1 | 0 = static run, 1 = dynamic run, captured at start |
| pat_sel | input | 2 | Test pattern select, captured at start |
| scan_en | output | 1 | Shift enable for all chains |
| scan_si | output | NUM_CHAINS | Serial data into each chain |
| scan_so | input | NUM_CHAINS | Serial data out of each chain |
| exposing | output | 1 | Chains loaded and held, exposure may run |
| done | output | 1 | Event target reached |
| upset_count | output | CNT_W | Isolated upsets found in static flushes |
| mass_count | output | CNT_W | Set/reset events found in static flushes |
| stuck_count | output | CNT_W | Persistent positions found in dynamic mode |
| stuck_seen | output | 1 | At least one persistent position in this run |

## Verification
Assertions check four properties on every cycle. Exposure ends only after a pause, and a start during exposure is ignored. `done` rises only once the two static counters meet the target. The stuck counter moves only in dynamic mode. The counters never fall except on a clear, and they hold once saturated. Some behaviour only the bench scenarios can show: whether a given injection pattern is classified as isolated upsets or as a set/reset event, whether flush alignment works for each pattern, whether the exposure cycle ends after the right pass, and whether a stuck element in dynamic mode yields exactly one count per affected position while a one-time flip yields none. A second instance with narrow counters exercises saturation.

// File: rtl/sct_pkg.sv
package sct_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FILL   = 3'd1,
        ST_HOLD   = 3'd2,
        ST_FLUSH  = 3'd3,
        ST_RECORD = 3'd4,
        ST_DYN    = 3'd5,
        ST_DONE   = 3'd6
    } sct_state_e;

    // Pattern bit for a given shift index (only the index parity matters).
    function automatic logic sct_pattern_bit(input logic [1:0] sel, input logic idx_lsb);
        return sel[1] ? (idx_lsb ^ sel[0]) : sel[0];
    endfunction

endpackage

// File: rtl/sct_sat_counter.sv
module sct_sat_counter #(
    parameter int CNT_W = 16,
    parameter int ADD_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [ADD_W-1:0] add,
    output logic [CNT_W-1:0] q,
    output logic [CNT_W-1:0] q_next
);
    localparam int SUM_W = ((CNT_W > ADD_W) ? CNT_W : ADD_W) + 1;
    localparam logic [SUM_W-1:0] MAX_S = {{(SUM_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        cnt_d = cnt_q;
        sum   = SUM_W'(cnt_q.val) + SUM_W'(add);
        if (clear)
            cnt_d.val = '0;
        else if (sum > MAX_S)
            cnt_d.val = {CNT_W{1'b1}};
        else
            cnt_d.val = sum[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign q      = cnt_q.val;
    assign q_next = cnt_d.val;

    // R9: a counter only moves down through a clear
    assert_no_decrease_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clear) |-> (q >= $past(q)));

    // R9: once at the top it stays there
    assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clear) && ($past(q) == {CNT_W{1'b1}})) |-> (q == {CNT_W{1'b1}}));

endmodule

// File: rtl/sct_flush_tally.sv
module sct_flush_tally #(
    parameter int CHAIN_LEN = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           cmp_en,
    input  logic                           exp_bit,
    input  logic                           so_bit,
    output logic [$clog2(CHAIN_LEN+1)-1:0] set_n,
    output logic [$clog2(CHAIN_LEN+1)-1:0] clr_n,
    output logic                           is_mass
);
    localparam int TALLY_W = $clog2(CHAIN_LEN+1);
    localparam int QUARTER = (CHAIN_LEN / 4 > 0) ? CHAIN_LEN / 4 : 1;
    localparam logic [TALLY_W-1:0] MASS_MIN = TALLY_W'(QUARTER);

    typedef struct packed {
        logic [TALLY_W-1:0] set_n;
        logic [TALLY_W-1:0] clr_n;
    } tally_t;

    tally_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clear) begin
            t_d = '0;
        end else if (cmp_en && (so_bit != exp_bit)) begin
            if (so_bit) t_d.set_n = t_q.set_n + 1'b1;
            else        t_d.clr_n = t_q.clr_n + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign set_n   = t_q.set_n;
    assign clr_n   = t_q.clr_n;
    assign is_mass = ((t_q.set_n >= MASS_MIN) && (t_q.clr_n == '0)) ||
                     ((t_q.clr_n >= MASS_MIN) && (t_q.set_n == '0));

    // R4: tallies move only while comparing or clearing
    assert_tally_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clear) && !$past(cmp_en)) |-> ($stable(set_n) && $stable(clr_n)));

endmodule

// File: rtl/sct_persist_track.sv
module sct_persist_track #(
    parameter int CHAIN_LEN = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         cmp_en,
    input  logic [$clog2(CHAIN_LEN)-1:0] idx,
    input  logic                         mism,
    output logic                         newly,
    output logic                         seen
);
    typedef struct packed {
        logic [CHAIN_LEN-1:0] prev;
        logic [CHAIN_LEN-1:0] rep;
    } track_t;

    track_t tr_d, tr_q;

    always_comb begin
        tr_d  = tr_q;
        newly = 1'b0;
        if (clear) begin
            tr_d = '0;
        end else if (cmp_en) begin
            if (mism && tr_q.prev[idx] && !tr_q.rep[idx]) begin
                newly         = 1'b1;
                tr_d.rep[idx] = 1'b1;
            end
            tr_d.prev[idx] = mism;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tr_q <= '0;
        else        tr_q <= tr_d;
    end

    assign seen = |tr_q.rep;

    // R8: a reported position stays reported until cleared
    assert_seen_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seen) && !$past(clear)) |-> seen);

endmodule

// File: rtl/shift_chain_tester.sv
module shift_chain_tester #(
    parameter int NUM_CHAINS    = 4,
    parameter int CHAIN_LEN     = 16,
    parameter int CNT_W         = 16,
    parameter int TARGET_EVENTS = 100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  pause,
    input  logic                  dyn_mode,
    input  logic [1:0]            pat_sel,
    output logic                  scan_en,
    output logic [NUM_CHAINS-1:0] scan_si,
    input  logic [NUM_CHAINS-1:0] scan_so,
    output logic                  exposing,
    output logic                  done,
    output logic [CNT_W-1:0]      upset_count,
    output logic [CNT_W-1:0]      mass_count,
    output logic [CNT_W-1:0]      stuck_count,
    output logic                  stuck_seen
);
    import sct_pkg::*;

    localparam int IDX_W      = $clog2(CHAIN_LEN);
    localparam int TALLY_W    = $clog2(CHAIN_LEN+1);
    localparam int UP_ADD_W   = $clog2(NUM_CHAINS*CHAIN_LEN+1);
    localparam int CH_ADD_W   = $clog2(NUM_CHAINS+1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAIN_LEN-1);

    typedef struct packed {
        sct_state_e       st;
        logic [IDX_W-1:0] idx;
        logic             primed;
        logic [1:0]       pat;
    } ctl_t;

    ctl_t c_d, c_q;

    logic                   start_ok;
    logic                   exp_bit;
    logic                   flush_cmp;
    logic                   dyn_cmp;
    logic                   in_record;
    logic [TALLY_W-1:0]     set_n  [NUM_CHAINS];
    logic [TALLY_W-1:0]     clr_n  [NUM_CHAINS];
    logic [NUM_CHAINS-1:0]  is_mass;
    logic [NUM_CHAINS-1:0]  newly;
    logic [NUM_CHAINS-1:0]  seen;
    logic [UP_ADD_W-1:0]    up_add;
    logic [CH_ADD_W-1:0]    mass_add;
    logic [CH_ADD_W-1:0]    stuck_add;
    logic [CNT_W-1:0]       upset_next;
    logic [CNT_W-1:0]       mass_next;
    logic [CNT_W-1:0]       stuck_next;
    logic                   target_hit;

    assign exp_bit   = sct_pattern_bit(c_q.pat, c_q.idx[0]);
    assign flush_cmp = (c_q.st == ST_FLUSH);
    assign dyn_cmp   = (c_q.st == ST_DYN) && c_q.primed && !pause;
    assign in_record = (c_q.st == ST_RECORD);

    // Per-chain flush tallies and persistence trackers
    for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_chain
        sct_flush_tally #(.CHAIN_LEN(CHAIN_LEN)) tally_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (c_q.st == ST_HOLD),
            .cmp_en  (flush_cmp),
            .exp_bit (exp_bit),
            .so_bit  (scan_so[g]),
            .set_n   (set_n[g]),
            .clr_n   (clr_n[g]),
            .is_mass (is_mass[g])
        );
        sct_persist_track #(.CHAIN_LEN(CHAIN_LEN)) track_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (start_ok),
            .cmp_en (dyn_cmp),
            .idx    (c_q.idx),
            .mism   (scan_so[g] != exp_bit),
            .newly  (newly[g]),
            .seen   (seen[g])
        );
    end

    always_comb begin
        up_add    = '0;
        mass_add  = '0;
        stuck_add = '0;
        for (int c = 0; c < NUM_CHAINS; c++) begin
            if (is_mass[c]) mass_add = mass_add + 1'b1;
            else            up_add   = up_add + UP_ADD_W'(set_n[c]) + UP_ADD_W'(clr_n[c]);
            if (newly[c])   stuck_add = stuck_add + 1'b1;
        end
    end

    sct_sat_counter #(.CNT_W(CNT_W), .ADD_W(UP_ADD_W)) upset_cnt_i (
        .clk(clk), .rst_n(rst_n), .clear(start_ok),
        .add(in_record ? up_add : '0), .q(upset_count), .q_next(upset_next)
    );
    sct_sat_counter #(.CNT_W(CNT_W), .ADD_W(CH_ADD_W)) mass_cnt_i (
        .clk(clk), .rst_n(rst_n), .clear(start_ok),
        .add(in_record ? mass_add : '0), .q(mass_count), .q_next(mass_next)
    );
    sct_sat_counter #(.CNT_W(CNT_W), .ADD_W(CH_ADD_W)) stuck_cnt_i (
        .clk(clk), .rst_n(rst_n), .clear(start_ok),
        .add(stuck_add), .q(stuck_count), .q_next(stuck_next)
    );

    assign target_hit = (32'(upset_next) + 32'(mass_next)) >= 32'(TARGET_EVENTS);

    always_comb begin
        c_d      = c_q;
        start_ok = 1'b0;
        case (c_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    start_ok   = 1'b1;
                    c_d.pat    = pat_sel;
                    c_d.idx    = '0;
                    c_d.primed = 1'b0;
                    c_d.st     = dyn_mode ? ST_DYN : ST_FILL;
                end
            end
            ST_FILL: begin
                c_d.idx = c_q.idx + 1'b1;
                if (c_q.idx == LAST_IDX) begin
                    c_d.idx = '0;
                    c_d.st  = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (pause) begin
                    c_d.idx = '0;
                    c_d.st  = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                c_d.idx = c_q.idx + 1'b1;
                if (c_q.idx == LAST_IDX) begin
                    c_d.idx = '0;
                    c_d.st  = ST_RECORD;
                end
            end
            ST_RECORD: begin
                c_d.st = target_hit ? ST_DONE : ST_HOLD;
            end
            ST_DYN: begin
                if (pause) begin
                    c_d.st = ST_IDLE;
                end else if (c_q.idx == LAST_IDX) begin
                    c_d.idx    = '0;
                    c_d.primed = 1'b1;
                end else begin
                    c_d.idx = c_q.idx + 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st     <= ST_IDLE;
            c_q.idx    <= '0;
            c_q.primed <= 1'b0;
            c_q.pat    <= 2'b00;
        end else begin
            c_q <= c_d;
        end
    end

    assign scan_en    = (c_q.st == ST_FILL) || (c_q.st == ST_FLUSH) || (c_q.st == ST_DYN);
    assign scan_si    = {NUM_CHAINS{exp_bit}};
    assign exposing   = (c_q.st == ST_HOLD);
    assign done       = (c_q.st == ST_DONE);
    assign stuck_seen = |seen;

    // R2: exposure is left only in answer to a pause
    assert_hold_until_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(exposing) |-> $past(pause));

    // R10: a start during exposure does not end it
    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && $past(exposing) && !$past(pause)) |-> exposing);

    // R6: completion only with the target met
    assert_done_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ((32'(upset_count) + 32'(mass_count)) >= 32'(TARGET_EVENTS)));

    // R8: persistence counting belongs to dynamic mode only
    assert_stuck_only_dynamic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start_ok) && ($past(c_q.st) != ST_DYN)) |-> $stable(stuck_count));

endmodule

// File: tb/shift_chain_tester_tb_top.sv
`timescale 1ns/1ps
module shift_chain_tester_tb_top;
    localparam int N = 4;
    localparam int L = 16;
    localparam int TARGET = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic pause = 1'b0;
    logic dyn_mode = 1'b0;
    logic [1:0] pat_sel = 2'b00;
    logic scan_en;
    logic [N-1:0] scan_si;
    logic [N-1:0] scan_so;
    logic exposing, done, stuck_seen;
    logic [15:0] upset_count, mass_count, stuck_count;

    logic s_en, s_exp, s_done, s_seen;
    logic [N-1:0] s_si;
    logic [3:0] s_up, s_mass, s_stk;

    logic [L-1:0] chain [N];
    logic [L-1:0] stk_m [N];
    logic [L-1:0] stk_v [N];

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit cmp_on = 0;

    always #2.5 clk = ~clk;

    shift_chain_tester #(.NUM_CHAINS(N), .CHAIN_LEN(L), .CNT_W(16), .TARGET_EVENTS(TARGET)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pause(pause), .dyn_mode(dyn_mode),
        .pat_sel(pat_sel), .scan_en(scan_en), .scan_si(scan_si), .scan_so(scan_so),
        .exposing(exposing), .done(done), .upset_count(upset_count),
        .mass_count(mass_count), .stuck_count(stuck_count), .stuck_seen(stuck_seen)
    );

    // Narrow-counter copy, fed the same chain outputs, for saturation
    shift_chain_tester #(.NUM_CHAINS(N), .CHAIN_LEN(L), .CNT_W(4), .TARGET_EVENTS(TARGET)) sat_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pause(pause), .dyn_mode(dyn_mode),
        .pat_sel(pat_sel), .scan_en(s_en), .scan_si(s_si), .scan_so(scan_so),
        .exposing(s_exp), .done(s_done), .upset_count(s_up),
        .mass_count(s_mass), .stuck_count(s_stk), .stuck_seen(s_seen)
    );

    // Behavioural chains with optional stuck elements
    initial begin
        for (int c = 0; c < N; c++) begin
            chain[c] = '0; stk_m[c] = '0; stk_v[c] = '0;
        end
    end

    always_comb for (int c = 0; c < N; c++) scan_so[c] = chain[c][L-1];

    always @(posedge clk) begin
        for (int c = 0; c < N; c++) begin
            logic [L-1:0] nv;
            nv = scan_en ? {chain[c][L-2:0], scan_si[c]} : chain[c];
            chain[c] <= (nv & ~stk_m[c]) | (stk_v[c] & stk_m[c]);
        end
    end

    // ---------------- reference model ----------------
    typedef enum int {M_IDLE, M_FILL, M_HOLD, M_FLUSH, M_REC, M_DYN, M_DONE} mst_e;
    mst_e m_st = M_IDLE;
    int m_idx = 0;
    bit m_primed = 0;
    logic [1:0] m_pat = 2'b00;
    int m_set [N];
    int m_clr [N];
    int m_up = 0, m_mass = 0, m_stk = 0;
    bit m_prev [N][L];
    bit m_rep [N][L];

    function automatic logic pat_at(input logic [1:0] sel, input int i);
        if (sel == 2'b00) return 1'b0;
        if (sel == 2'b01) return 1'b1;
        if (sel == 2'b10) return logic'(i % 2);
        return logic'(1 - (i % 2));
    endfunction

    function automatic int sat16(input int v);
        return (v > 65535) ? 65535 : v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = M_IDLE; m_idx = 0; m_primed = 0; m_pat = 2'b00;
            m_up = 0; m_mass = 0; m_stk = 0;
            for (int c = 0; c < N; c++) begin
                m_set[c] = 0; m_clr[c] = 0;
                for (int k = 0; k < L; k++) begin m_prev[c][k] = 0; m_rep[c][k] = 0; end
            end
        end else begin
            case (m_st)
                M_IDLE, M_DONE: if (start) begin
                    m_up = 0; m_mass = 0; m_stk = 0; m_pat = pat_sel; m_idx = 0; m_primed = 0;
                    for (int c = 0; c < N; c++)
                        for (int k = 0; k < L; k++) begin m_prev[c][k] = 0; m_rep[c][k] = 0; end
                    m_st = dyn_mode ? M_DYN : M_FILL;
                end
                M_FILL: begin
                    m_idx++;
                    if (m_idx == L) begin m_idx = 0; m_st = M_HOLD; end
                end
                M_HOLD: begin
                    for (int c = 0; c < N; c++) begin m_set[c] = 0; m_clr[c] = 0; end
                    if (pause) begin m_idx = 0; m_st = M_FLUSH; end
                end
                M_FLUSH: begin
                    for (int c = 0; c < N; c++) begin
                        logic ob;
                        ob = chain[c][L-1];
                        if (ob != pat_at(m_pat, m_idx)) begin
                            if (ob) m_set[c]++; else m_clr[c]++;
                        end
                    end
                    m_idx++;
                    if (m_idx == L) begin m_idx = 0; m_st = M_REC; end
                end
                M_REC: begin
                    for (int c = 0; c < N; c++) begin
                        if ((m_set[c] >= L/4 && m_clr[c] == 0) || (m_clr[c] >= L/4 && m_set[c] == 0))
                            m_mass = sat16(m_mass + 1);
                        else
                            m_up = sat16(m_up + m_set[c] + m_clr[c]);
                    end
                    m_st = (m_up + m_mass >= TARGET) ? M_DONE : M_HOLD;
                end
                M_DYN: begin
                    if (pause) m_st = M_IDLE;
                    else begin
                        if (m_primed) begin
                            for (int c = 0; c < N; c++) begin
                                bit mm;
                                mm = (chain[c][L-1] != pat_at(m_pat, m_idx));
                                if (mm && m_prev[c][m_idx] && !m_rep[c][m_idx]) begin
                                    m_stk = sat16(m_stk + 1);
                                    m_rep[c][m_idx] = 1;
                                end
                                m_prev[c][m_idx] = mm;
                            end
                        end
                        m_idx++;
                        if (m_idx == L) begin m_idx = 0; m_primed = 1; end
                    end
                end
                default: m_st = M_IDLE;
            endcase
        end
    end

    task automatic chk(input int act, input int exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            logic m_en;
            bit any;
            m_en = (m_st == M_FILL) || (m_st == M_FLUSH) || (m_st == M_DYN);
            chk(int'(scan_en), int'(m_en), "R2 shift enable");
            if (m_en) chk(int'(scan_si), int'({N{pat_at(m_pat, m_idx)}}), "R1 serial pattern");
            chk(int'(exposing), int'(m_st == M_HOLD), "R2 exposing");
            chk(int'(done), int'(m_st == M_DONE), "R6 done");
            chk(int'(upset_count), m_up, "R4 upset count");
            chk(int'(mass_count), m_mass, "R5 mass count");
            chk(int'(stuck_count), m_stk, "R8 stuck count");
            any = 0;
            for (int c = 0; c < N; c++) for (int k = 0; k < L; k++) any |= m_rep[c][k];
            chk(int'(stuck_seen), int'(any), "R8 stuck seen");
        end
    end

    task automatic summary_and_exit();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
            summary_and_exit();
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_start(input logic dm, input logic [1:0] ps);
        dyn_mode = dm; pat_sel = ps; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_pause();
        pause = 1'b1;
        @(negedge clk);
        pause = 1'b0;
    endtask

    task automatic wait_hold_or_done();
        for (int i = 0; i < 200; i++) begin
            if (exposing || done) break;
            @(negedge clk);
        end
    endtask

    task automatic flip(input int c, input int pos);
        chain[c][pos] = ~chain[c][pos];
    endtask

    initial begin
        do_reset();
        cmp_on = 1;
        // Reset state
        chk(int'(scan_en), 0, "R2 reset shift enable");
        chk(int'(exposing), 0, "R2 reset exposing");
        chk(int'(done), 0, "R6 reset done");
        chk(int'(upset_count) + int'(mass_count) + int'(stuck_count), 0, "R9 reset counters");

        // R10: pause while idle does nothing
        pulse_pause();
        repeat (3) @(negedge clk);
        chk(int'(scan_en), 0, "R10 pause in idle");

        // Static run, all-ones pattern
        pulse_start(1'b0, 2'b01);
        wait_hold_or_done();
        chk(int'(chain[2]), 16'hFFFF, "R1 all-ones fill");
        flip(0, 0); flip(0, 1); flip(0, 2); flip(0, 3);   // mass event
        flip(1, 4); flip(1, 8); flip(1, 12);              // three upsets
        flip(3, 9);                                        // one upset
        // R10: start during exposure ignored
        pulse_start(1'b1, 2'b00);
        chk(int'(exposing), 1, "R10 start ignored while exposing");
        pulse_pause();
        wait_hold_or_done();
        chk(int'(upset_count), 4, "R4 isolated upsets");
        chk(int'(mass_count), 1, "R5 mass set/reset event");
        chk(int'(chain[0]), 16'hFFFF, "R3 refill after flush");

        // Clean pass changes nothing
        pulse_pause();
        wait_hold_or_done();
        chk(int'(upset_count), 4, "R4 clean flush");
        chk(int'(mass_count), 1, "R5 clean flush");

        // Three flips per chain per pass (below the quarter threshold) until done
        for (int p = 1; p <= 8; p++) begin
            for (int c = 0; c < N; c++) begin flip(c, 5); flip(c, 9); flip(c, 13); end
            pulse_pause();
            wait_hold_or_done();
            chk(int'(upset_count), 4 + 12 * p, "R4 accumulated upsets");
            chk(int'(done), (p == 8) ? 1 : 0, "R6 done at target");
        end
        chk(int'(s_up), 15, "R9 saturated upset counter");
        chk(int'(s_mass), 1, "R9 narrow mass counter");

        // Pause while done has no effect
        pulse_pause();
        repeat (20) @(negedge clk);
        chk(int'(done), 1, "R6 done held");
        chk(int'(upset_count), 100, "R10 pause ignored in done");

        // Alternating pattern, mixed-direction vs same-direction flips
        do_reset();
        pulse_start(1'b0, 2'b10);
        wait_hold_or_done();
        chk(int'(chain[1]), 16'h5555, "R1 alternating fill");
        flip(0, 0); flip(0, 2); flip(0, 4); flip(0, 1); flip(0, 3);
        flip(1, 0); flip(1, 2); flip(1, 4); flip(1, 6);
        pulse_pause();
        wait_hold_or_done();
        chk(int'(upset_count), 5, "R5 mixed directions are upsets");
        chk(int'(mass_count), 1, "R5 same direction is one event");
        chk(int'(chain[1]), 16'h5555, "R3 alternating refill");

        // Dynamic mode, all ones, stuck-at-0 element in chain 2
        do_reset();
        stk_m[2] = 16'h0020; stk_v[2] = 16'h0000;
        pulse_start(1'b1, 2'b01);
        repeat (L + 3) @(negedge clk);
        chk(int'(stuck_count), 0, "R7 no counts during priming");
        repeat (3 * L) @(negedge clk);
        chk(int'(stuck_count), 16, "R8 stuck positions all ones");
        chk(int'(stuck_seen), 1, "R8 stuck seen");
        repeat (L) @(negedge clk);
        chk(int'(stuck_count), 16, "R8 counted once per position");
        pulse_pause();
        repeat (2) @(negedge clk);
        chk(int'(scan_en), 0, "R7 pause stops dynamic mode");
        stk_m[2] = '0;

        // Dynamic, inverse alternating, stuck-at-0 in chain 1, one transient in chain 0
        do_reset();
        stk_m[1] = 16'h0008; stk_v[1] = 16'h0000;
        pulse_start(1'b1, 2'b11);
        repeat (L + 4) @(negedge clk);
        flip(0, 7);
        repeat (4 * L) @(negedge clk);
        chk(int'(stuck_count), 8, "R8 stuck positions alternating, transient ignored");
        stk_m[1] = '0;
        pulse_pause();
        repeat (3) @(negedge clk);

        summary_and_exit();
    end

endmodule